// File: doc/BRIEF.md
# Two-Plane Hardware Cursor Overlay

This block places a 64x64 monochrome cursor over a stream of 32-bit display pixels. Software programs the cursor through a small register port. The programmable state is a bitmap base address, a screen position, a hotspot adjustment, two 24-bit colours, an enable bit and the active display size. The bitmap sits in a byte-wide synchronous memory. Each cursor line occupies 16 bytes: a transparency (AND) plane followed by a colour/invert (XOR) plane.

During the horizontal blanking before each line, the display pipeline pulses `fetch_stb` with the number of the line that comes next. If that line crosses the cursor, the block reads that line's 16 bitmap bytes into a line buffer. Pixels then enter with their x coordinate. Each pixel leaves two clocks later in one of three forms: replaced by a cursor colour, bitwise inverted, or unchanged.

A lock bit freezes the cursor definition that the display uses. Software can then rewrite the position, base, hotspot and colours, and all of these changes take effect together when the lock is released.

Top module: `cursor_overlay`

## Requirements
- R1: Every pixel presented with `pix_valid` appears on `out_pix` with `out_valid` exactly two clocks later. With no input, `out_valid` is low.
- R2: After `fetch_stb` on a line that the cursor covers, the block issues exactly 16 single-byte reads at consecutive addresses. The first address is start + 16*row, where start = (base & 0x07fffff0) - hotX - 16*hotY and row = line - cursorY. The line is usable 20 clocks after the strobe.
- R3: Cursor column c = x - cursorX, for 0 <= c < 64. Byte c/8 of the line holds the AND bit and byte 8 + c/8 holds the XOR bit, both at bit 7 - (c mod 8), so the MSB is the leftmost pixel. Pixels outside the 64 columns pass unchanged.
- R4: A pixel with AND=0 becomes {colour1, 8'hff} when XOR=1 and {colour0, 8'hff} when XOR=0.
- R5: A pixel with AND=1 is inverted bitwise when XOR=1 and passed unchanged when XOR=0.
- R6: Pixels with x >= (display-width field + 1) * 8 pass unchanged, even inside the cursor box.
- R7: A line outside cursorY..cursorY+63, or above the vertical display field, issues no bitmap reads and passes all of its pixels unchanged.
- R8: With the enable bit (control register bit 0) clear, every pixel passes unchanged.
- R9: Register addresses are 0 base, 1 position, 2 hotspot, 3 colour0, 4 colour1, 5 control, 6 display size. Writes keep only these bits, and each register reads back its stored value:
  - base: 0x87fffff0
  - position: 0x3fff0fff, with X in [29:16] and Y in [11:0]
  - hotspot: 0x003f003f, with X in [21:16] and Y in [5:0]
  - colours: 0x00ffffff
  - display size: 0x07ff0fff, with the width field in [26:16] and the last visible line in [11:0]
- R10: The lock is bit 31. Writing the base, position or hotspot register sets or clears it from bit 31 of the written data. Reads of all three registers return the lock in bit 31.
- R11: While locked, new base, position, hotspot or colour values have no effect on the output. They take effect from the first clock after unlock.
- R12: After reset every register reads zero, `out_valid` is low and no memory read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address, shared by reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| fetch_stb | input | 1 | Start of bitmap fetch for the next line |
| fetch_line | input | 12 | Screen line about to be displayed |
| mem_rd_en | output | 1 | Bitmap memory read request |
| mem_addr | output | MEM_AW | Bitmap byte address |
| mem_rdata | input | 8 | Bitmap byte, valid one clock after the request |
| pix_valid | input | 1 | Input pixel valid |
| pix_x | input | 14 | Input pixel x coordinate |
| pix_in | input | 32 | Underlying display pixel |
| out_valid | output | 1 | Output pixel valid |
| out_pix | output | 32 | Pixel after the cursor overlay |

## Verification
A wrong fetch start or byte index shows up on the first line that crosses the cursor. It appears as a shifted or mirrored AND/XOR pattern in the output pixels, about twenty clocks after the strobe. A lock or latch fault shows up on the next line drawn after a locked reprogramming: the cursor appears at the new position or in the new colour too early, or stays at the old one after unlock. A fault in the two-stage pipeline or the edge checks shows up within two clocks as a pixel with the wrong timing, or as a cursor pixel drawn past the width limit.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
    localparam int CUR_DIM     = 64;
    localparam int COL_W       = $clog2(CUR_DIM);
    localparam int PLANE_BYTES = CUR_DIM / 8;
    localparam int LINE_BYTES  = 2 * PLANE_BYTES;
    localparam int LINE_BITS   = LINE_BYTES * 8;
    localparam int BIDX_W      = $clog2(LINE_BYTES);
    localparam int PIX_W       = 32;
    localparam int CLR_W       = 24;
    localparam int XPOS_W      = 14;
    localparam int YPOS_W      = 12;
    localparam int REG_AW      = 3;
    localparam int LOCK_BIT    = 31;

    localparam logic [REG_AW-1:0] RA_BASE = 3'd0;
    localparam logic [REG_AW-1:0] RA_POS  = 3'd1;
    localparam logic [REG_AW-1:0] RA_HOT  = 3'd2;
    localparam logic [REG_AW-1:0] RA_COL0 = 3'd3;
    localparam logic [REG_AW-1:0] RA_COL1 = 3'd4;
    localparam logic [REG_AW-1:0] RA_CTRL = 3'd5;
    localparam logic [REG_AW-1:0] RA_DISP = 3'd6;

    localparam logic [31:0] MASK_BASE = 32'h87ff_fff0;
    localparam logic [31:0] MASK_ADDR = 32'h07ff_fff0;
    localparam logic [31:0] MASK_POS  = 32'h3fff_0fff;
    localparam logic [31:0] MASK_HOT  = 32'h003f_003f;
    localparam logic [31:0] MASK_DISP = 32'h07ff_0fff;
endpackage

// File: rtl/cursor_regs.sv
module cursor_regs
    import cursor_pkg::*;
#(
    parameter int MEM_AW = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [REG_AW-1:0]   addr,
    input  logic [31:0]         wdata,
    output logic [31:0]         rdata,
    output logic                enable,
    output logic [XPOS_W-1:0]   act_x,
    output logic [YPOS_W-1:0]   act_y,
    output logic [MEM_AW-1:0]   act_start,
    output logic [CLR_W-1:0]    act_c0,
    output logic [CLR_W-1:0]    act_c1,
    output logic [XPOS_W:0]     hlimit,
    output logic [YPOS_W-1:0]   vlast
);
    typedef struct packed {
        logic [31:0]       base;
        logic [31:0]       pos;
        logic [31:0]       hot;
        logic [CLR_W-1:0]  c0;
        logic [CLR_W-1:0]  c1;
        logic              en;
        logic [31:0]       disp;
        logic [XPOS_W-1:0] ax;
        logic [YPOS_W-1:0] ay;
        logic [MEM_AW-1:0] astart;
        logic [CLR_W-1:0]  ac0;
        logic [CLR_W-1:0]  ac1;
    } regs_t;

    regs_t q, d;
    logic [31:0]   start_full;
    logic [XPOS_W:0] hcells;
    logic          locked;

    assign locked     = q.base[LOCK_BIT];
    assign start_full = (q.base & MASK_ADDR) - {26'b0, q.hot[21:16]}
                        - {22'b0, q.hot[5:0], 4'b0000};

    always_comb begin
        d = q;
        if (!locked) begin
            d.ax     = q.pos[29:16];
            d.ay     = q.pos[11:0];
            d.astart = start_full[MEM_AW-1:0];
            d.ac0    = q.c0;
            d.ac1    = q.c1;
        end
        if (wr_en) begin
            case (addr)
                RA_BASE: d.base = wdata & MASK_BASE;
                RA_POS: begin
                    d.pos = wdata & MASK_POS;
                    d.base[LOCK_BIT] = wdata[LOCK_BIT];
                end
                RA_HOT: begin
                    d.hot = wdata & MASK_HOT;
                    d.base[LOCK_BIT] = wdata[LOCK_BIT];
                end
                RA_COL0: d.c0   = wdata[CLR_W-1:0];
                RA_COL1: d.c1   = wdata[CLR_W-1:0];
                RA_CTRL: d.en   = wdata[0];
                RA_DISP: d.disp = wdata & MASK_DISP;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (addr)
            RA_BASE: rdata = q.base;
            RA_POS:  rdata = q.pos | {locked, 31'b0};
            RA_HOT:  rdata = q.hot | {locked, 31'b0};
            RA_COL0: rdata = {8'b0, q.c0};
            RA_COL1: rdata = {8'b0, q.c1};
            RA_CTRL: rdata = {31'b0, q.en};
            RA_DISP: rdata = q.disp;
            default: rdata = '0;
        endcase
    end

    assign hcells    = {{(XPOS_W-10){1'b0}}, q.disp[26:16]} + 1'b1;
    assign hlimit    = {hcells[XPOS_W-3:0], 3'b000};
    assign vlast     = q.disp[11:0];
    assign enable    = q.en;
    assign act_x     = q.ax;
    assign act_y     = q.ay;
    assign act_start = q.astart;
    assign act_c0    = q.ac0;
    assign act_c1    = q.ac1;

    // R11: a locked definition does not move
    a_r11_lock_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> ($stable(q.ax) && $stable(q.ay) && $stable(q.astart)
                    && $stable(q.ac0) && $stable(q.ac1)));
    // R11: unlocked, the live position follows the programmed one a clock later
    a_r11_unlock_applies: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |=> (q.ax == $past(q.pos[29:16])) && (q.ay == $past(q.pos[11:0])));
    // R10: a position write carries the lock
    a_r10_pos_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == RA_POS) |=> locked == $past(wdata[LOCK_BIT]));
endmodule

// File: rtl/cursor_fetch.sv
module cursor_fetch
    import cursor_pkg::*;
#(
    parameter int MEM_AW = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 stb,
    input  logic [YPOS_W-1:0]    line,
    input  logic [YPOS_W-1:0]    act_y,
    input  logic [YPOS_W-1:0]    vlast,
    input  logic [MEM_AW-1:0]    start,
    output logic                 mem_rd_en,
    output logic [MEM_AW-1:0]    mem_addr,
    input  logic [7:0]           mem_rdata,
    output logic                 row_valid,
    output logic [LINE_BITS-1:0] row_bits
);
    localparam logic [BIDX_W-1:0] LAST_IDX = BIDX_W'(LINE_BYTES - 1);

    typedef struct packed {
        logic                 rd_en;
        logic [MEM_AW-1:0]    addr;
        logic [BIDX_W-1:0]    idx;
        logic                 ret_en;
        logic [BIDX_W-1:0]    ret_idx;
        logic [LINE_BITS-1:0] fbuf;
        logic [LINE_BITS-1:0] dbuf;
        logic                 valid;
    } fetch_t;

    fetch_t q, d;
    logic [YPOS_W:0]  diff;
    logic [COL_W-1:0] row;
    logic             row_hit;

    assign diff    = {1'b0, line} - {1'b0, act_y};
    assign row     = diff[COL_W-1:0];
    assign row_hit = !diff[YPOS_W] && (diff[YPOS_W-1:COL_W] == '0) && (line <= vlast);

    always_comb begin
        d = q;
        d.ret_en  = q.rd_en;
        d.ret_idx = q.idx;
        if (q.rd_en) begin
            if (q.idx == LAST_IDX) begin
                d.rd_en = 1'b0;
            end else begin
                d.idx  = q.idx + 1'b1;
                d.addr = q.addr + 1'b1;
            end
        end
        if (q.ret_en) begin
            d.fbuf[{q.ret_idx, 3'b000} +: 8] = mem_rdata;
            if (q.ret_idx == LAST_IDX) begin
                d.dbuf  = d.fbuf;
                d.valid = 1'b1;
            end
        end
        if (stb) begin
            d.valid  = 1'b0;
            d.ret_en = 1'b0;
            d.rd_en  = row_hit;
            d.idx    = '0;
            d.addr   = start + {{(MEM_AW-COL_W-BIDX_W){1'b0}}, row, {BIDX_W{1'b0}}};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_rd_en = q.rd_en;
    assign mem_addr  = q.addr;
    assign row_valid = q.valid;
    assign row_bits  = q.dbuf;

    // R2: a line becomes usable only after its last byte has returned
    a_r2_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.valid) |-> $past(q.ret_en && q.ret_idx == LAST_IDX));
    // R2: consecutive reads step by one byte
    a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (q.rd_en && $past(q.rd_en) && !$past(stb)) |-> q.addr == $past(q.addr) + 1'b1);
    // R7: a strobe for an uncovered line issues no read
    a_r7_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !row_hit) |=> !q.rd_en);
endmodule

// File: rtl/cursor_pixel.sv
module cursor_pixel
    import cursor_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic [XPOS_W-1:0]    act_x,
    input  logic [CLR_W-1:0]     act_c0,
    input  logic [CLR_W-1:0]     act_c1,
    input  logic [XPOS_W:0]      hlimit,
    input  logic                 row_valid,
    input  logic [LINE_BITS-1:0] row_bits,
    input  logic                 pix_valid,
    input  logic [XPOS_W-1:0]    pix_x,
    input  logic [PIX_W-1:0]     pix_in,
    output logic                 out_valid,
    output logic [PIX_W-1:0]     out_pix
);
    typedef struct packed {
        logic             v1;
        logic             hit1;
        logic             a1;
        logic             x1;
        logic [PIX_W-1:0] p1;
        logic             vo;
        logic [PIX_W-1:0] po;
    } pix_t;

    pix_t q, d;
    logic [XPOS_W:0]  diff;
    logic [COL_W-1:0] col;
    logic [COL_W-1:0] bidx;
    logic             in_box;
    logic             hit;

    assign diff   = {1'b0, pix_x} - {1'b0, act_x};
    assign col    = diff[COL_W-1:0];
    assign bidx   = {col[COL_W-1:3], ~col[2:0]};
    assign in_box = !diff[XPOS_W] && (diff[XPOS_W-1:COL_W] == '0);
    assign hit    = enable && row_valid && in_box && ({1'b0, pix_x} < hlimit);

    always_comb begin
        d      = q;
        d.v1   = pix_valid;
        d.hit1 = pix_valid && hit;
        d.a1   = row_bits[{1'b0, bidx}];
        d.x1   = row_bits[{1'b1, bidx}];
        d.p1   = pix_in;
        d.vo   = q.v1;
        if (!q.hit1)   d.po = q.p1;
        else if (q.a1) d.po = q.x1 ? ~q.p1 : q.p1;
        else           d.po = {q.x1 ? act_c1 : act_c0, 8'hff};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_valid = q.vo;
    assign out_pix   = q.po;

    // R1: output valid follows the first stage by one clock
    a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(q.v1));
    // R3: a pixel outside the cursor leaves unchanged
    a_r3_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (q.v1 && !q.hit1) |=> q.po == $past(q.p1));
    // R4: a colour pixel carries the opaque low byte
    a_r4_opaque: assert property (@(posedge clk) disable iff (!rst_n)
        (q.v1 && q.hit1 && !q.a1) |=> q.po[7:0] == 8'hff);
    // R8: disabled cursor never hits
    a_r8_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !enable) |=> !q.hit1);
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
    import cursor_pkg::*;
#(
    parameter int MEM_AW = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr_en,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic                fetch_stb,
    input  logic [YPOS_W-1:0]   fetch_line,
    output logic                mem_rd_en,
    output logic [MEM_AW-1:0]   mem_addr,
    input  logic [7:0]          mem_rdata,
    input  logic                pix_valid,
    input  logic [XPOS_W-1:0]   pix_x,
    input  logic [PIX_W-1:0]    pix_in,
    output logic                out_valid,
    output logic [PIX_W-1:0]    out_pix
);
    logic                 enable;
    logic [XPOS_W-1:0]    act_x;
    logic [YPOS_W-1:0]    act_y;
    logic [MEM_AW-1:0]    act_start;
    logic [CLR_W-1:0]     act_c0;
    logic [CLR_W-1:0]     act_c1;
    logic [XPOS_W:0]      hlimit;
    logic [YPOS_W-1:0]    vlast;
    logic                 row_valid;
    logic [LINE_BITS-1:0] row_bits;

    cursor_regs #(.MEM_AW(MEM_AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .enable(enable),
        .act_x(act_x), .act_y(act_y), .act_start(act_start),
        .act_c0(act_c0), .act_c1(act_c1), .hlimit(hlimit), .vlast(vlast)
    );

    cursor_fetch #(.MEM_AW(MEM_AW)) u_fetch (
        .clk(clk), .rst_n(rst_n), .stb(fetch_stb), .line(fetch_line),
        .act_y(act_y), .vlast(vlast), .start(act_start),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .row_valid(row_valid), .row_bits(row_bits)
    );

    cursor_pixel u_pixel (
        .clk(clk), .rst_n(rst_n), .enable(enable), .act_x(act_x),
        .act_c0(act_c0), .act_c1(act_c1), .hlimit(hlimit),
        .row_valid(row_valid), .row_bits(row_bits),
        .pix_valid(pix_valid), .pix_x(pix_x), .pix_in(pix_in),
        .out_valid(out_valid), .out_pix(out_pix)
    );

    // R12: nothing is read from memory while in reset's aftermath without a strobe
    a_r12_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd_en) |-> $past(fetch_stb));
endmodule

// File: tb/tb_cursor_overlay.sv
module tb_cursor_overlay;
    localparam int AW = 10;
    localparam int MSZ = 1 << AW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fetch_stb = 1'b0;
    logic [11:0] fetch_line = '0;
    logic        mem_rd_en;
    logic [AW-1:0] mem_addr;
    logic [7:0]  mem_rdata = '0;
    logic        pix_valid = 1'b0;
    logic [13:0] pix_x = '0;
    logic [31:0] pix_in = '0;
    logic        out_valid;
    logic [31:0] out_pix;

    cursor_overlay #(.MEM_AW(AW)) dut (.*);

    always #2 clk = ~clk;

    int nchk = 0, nfail = 0, rd_cnt = 0, first_addr = 0;
    bit done = 0;

    function automatic logic [7:0] memf(int a);
        logic [31:0] t;
        t = a * 37 + (a >> 3) * 11 + 32'h5a;
        return t[7:0] ^ t[15:8];
    endfunction

    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rdata <= memf(int'(mem_addr));
            if (rd_cnt == 0) first_addr = int'(mem_addr);
            rd_cnt = rd_cnt + 1;
        end
    end

    // model: programmed and live cursor definitions
    logic [31:0] m_base = 0, m_pos = 0, m_hot = 0, m_c0 = 0, m_c1 = 0;
    logic        m_lock = 0, m_en = 0;
    int m_hf = 0, m_vf = 0;
    int a_start = 0, a_x = 0, a_y = 0;
    logic [23:0] a_c0 = 0, a_c1 = 0;
    bit l_valid = 0;
    int l_row = 0;

    function automatic void sync_live();
        a_start = int'(m_base & 32'h07ff_fff0) - int'(m_hot[21:16]) - 16 * int'(m_hot[5:0]);
        a_x = int'(m_pos[29:16]);
        a_y = int'(m_pos[11:0]);
        a_c0 = m_c0[23:0];
        a_c1 = m_c1[23:0];
    endfunction

    task automatic chk(logic [31:0] got, logic [31:0] exp, string tag);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] v);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr_en = 1'b0;
        case (a)
            3'd0: begin m_base = v & 32'h07ff_fff0; m_lock = v[31]; end
            3'd1: begin m_pos = v & 32'h3fff_0fff; m_lock = v[31]; end
            3'd2: begin m_hot = v & 32'h003f_003f; m_lock = v[31]; end
            3'd3: m_c0 = v & 32'h00ff_ffff;
            3'd4: m_c1 = v & 32'h00ff_ffff;
            3'd5: m_en = v[0];
            3'd6: begin m_hf = int'(v[26:16]); m_vf = int'(v[11:0]); end
            default: ;
        endcase
        if (!m_lock) sync_live();
        @(negedge clk);
    endtask

    task automatic rdchk(logic [2:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        reg_addr = a;
        #1 chk(reg_rdata, exp, tag);
    endtask

    task automatic fetch(int line);
        int row;
        @(negedge clk);
        rd_cnt = 0;
        fetch_stb = 1'b1; fetch_line = 12'(line);
        @(negedge clk);
        fetch_stb = 1'b0;
        repeat (20) @(negedge clk);
        row = line - a_y;
        l_valid = (row >= 0) && (row < 64) && (line <= m_vf);
        l_row = row;
        if (l_valid) begin
            chk(32'(rd_cnt), 32'd16, "R2 read count");
            chk(32'(first_addr), 32'((a_start + row * 16) & (MSZ - 1)), "R2 start address");
        end else begin
            chk(32'(rd_cnt), 32'd0, "R7 no reads");
        end
    endtask

    function automatic logic [31:0] exp_pix(int x, logic [31:0] p, output string tag);
        int col, ba;
        logic [7:0] ab, xb;
        logic a, xo;
        if (!m_en) begin tag = "R8"; return p; end
        if (!l_valid) begin tag = "R7"; return p; end
        if (x >= (m_hf + 1) * 8) begin tag = "R6"; return p; end
        col = x - a_x;
        if (col < 0 || col >= 64) begin tag = "R3"; return p; end
        ba = a_start + l_row * 16 + col / 8;
        ab = memf(ba & (MSZ - 1));
        xb = memf((ba + 8) & (MSZ - 1));
        a  = ab[7 - col % 8];
        xo = xb[7 - col % 8];
        if (!a) begin tag = "R4"; return {xo ? a_c1 : a_c0, 8'hff}; end
        tag = "R5";
        return xo ? ~p : p;
    endfunction

    task automatic run_pix(int x0, int n, string force_tag);
        logic [31:0] ex [0:127];
        string tg [0:127];
        for (int i = 0; i < n + 2; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                chk(32'(out_valid), 32'd1, "R1 valid at two clocks");
                chk(out_pix, ex[i-2], force_tag != "" ? force_tag : tg[i-2]);
            end
            if (i < n) begin
                pix_valid = 1'b1;
                pix_x = 14'(x0 + i);
                pix_in = $urandom;
                ex[i] = exp_pix(x0 + i, pix_in, tg[i]);
            end else begin
                pix_valid = 1'b0;
            end
        end
        @(negedge clk);
        chk(32'(out_valid), 32'd0, "R1 idle");
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        chk(32'(out_valid), 0, "R12 out_valid");
        chk(32'(mem_rd_en), 0, "R12 mem_rd_en");
        rst_n = 1'b1;
        for (int a = 0; a < 7; a++) rdchk(3'(a), 32'd0, "R12 register reset");
        chk(32'(out_valid), 0, "R12 out_valid after reset");

        wr(3'd0, 32'h7000_010f); rdchk(3'd0, 32'h0000_0100, "R9 base mask");
        wr(3'd1, 32'h4028_f005); rdchk(3'd1, 32'h0028_0005, "R9 position mask");
        wr(3'd2, 32'h00c3_0042); rdchk(3'd2, 32'h0003_0002, "R9 hotspot mask");
        wr(3'd3, 32'hab12_3456); rdchk(3'd3, 32'h0012_3456, "R9 colour0 mask");
        wr(3'd4, 32'h00fe_dcba); rdchk(3'd4, 32'h00fe_dcba, "R9 colour1");
        wr(3'd6, 32'hf84f_01df); rdchk(3'd6, 32'h004f_01df, "R9 display mask");
        wr(3'd5, 32'h0000_0001); rdchk(3'd5, 32'h0000_0001, "R9 control");

        fetch(5);  run_pix(30, 80, "");   // R3 R4 R5 first row
        fetch(68); run_pix(34, 74, "");   // last row
        fetch(69); run_pix(36, 40, "");   // R7 below cursor
        fetch(4);  run_pix(36, 40, "");   // R7 above cursor

        for (int k = 0; k < 10; k++) begin
            if (k == 5) begin
                wr(3'd1, {2'b0, 14'($urandom_range(0, 200)), 4'b0, 12'($urandom_range(0, 30))});
                wr(3'd3, $urandom); wr(3'd4, $urandom);
            end
            fetch($urandom_range(0, 100));
            run_pix($urandom_range(0, 180), 100, "");
        end
        wr(3'd1, 32'h0028_0005);

        wr(3'd6, 32'h0007_01df);            // width 64
        fetch(10); run_pix(36, 40, "");     // R6 cut at x 64
        wr(3'd6, 32'h004f_0007);            // last line 7
        fetch(10); run_pix(40, 16, "");     // R7 vertical limit
        wr(3'd6, 32'h004f_01df);

        wr(3'd5, 32'h0); fetch(10); run_pix(40, 20, "");   // R8
        wr(3'd5, 32'h1);

        // R10 lock via position register
        wr(3'd1, 32'h8028_0005);
        rdchk(3'd1, 32'h8028_0005, "R10 lock in position");
        rdchk(3'd0, 32'h8000_0100, "R10 lock in base");
        rdchk(3'd2, 32'h8003_0002, "R10 lock in hotspot");
        // R11 changes while locked are held back
        wr(3'd1, 32'h8064_0003);
        wr(3'd3, 32'h0011_2233);
        wr(3'd2, 32'h8001_0001);
        fetch(8); run_pix(30, 80, "R11 locked shows old cursor");
        wr(3'd2, 32'h0001_0001);            // unlock
        rdchk(3'd1, 32'h0064_0003, "R10 unlock clears lock");
        fetch(8); run_pix(90, 80, "R11 new cursor after unlock");
        // R10 lock via base register
        wr(3'd0, 32'h8000_0100);
        rdchk(3'd1, 32'h8064_0003, "R10 base write locks");
        wr(3'd0, 32'h0000_0100);
        rdchk(3'd2, 32'h0001_0001, "R10 base write unlocks");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule